// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to sixteen pins, seen by software as a small bank of 32-bit registers on a simple bus. The bus has a byte address, a write strobe, write data, and a read data word that follows the address combinationally. For every pin, a direction bit chooses between driving the pin from an output latch and leaving it as an input. Incoming pin levels pass through a two-stage synchroniser before software reads them and before they reach the interrupt logic.

Each pin has its own event detector. A 3-bit mode code selects the event: falling edge, rising edge, either edge, low level or high level. An event latches a status bit only while the pin's enable bit is set. Software clears status with write-one-to-clear writes. A mask, controlled through separate write-one set and clear registers, hides status bits from the display view and from the single combined interrupt output. A soft-reset register holds every port register at its reset value while its bit is 1, and releases them when 0 is written.

Word map (byte address = word × 4): 0 enable, 1 status, 2 display, 3 clear, 4 mask set (reads the mask), 5 mask clear, 6 output, 7 input, 8 direction, 9 mode low, 10 mode high, 11 unused, 15 soft reset. Any other word, and any address with a bit set above the sixteen-word window, reads 0 and ignores writes.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0, `pinOe` and `pinOut` are 0 and `irqOut` is 0. All pins are inputs, no interrupt is enabled, no mask is set and every mode code is 0.
- R2: `pinOe` equals the direction register (bit value 1 = output) and `pinOut` equals the output register. Bits at or above `PIN_COUNT` in either register read back as 0 and are never stored.
- R3: The input register (word 7) returns the pin levels after two clock edges of synchronisation, and bits at or above `PIN_COUNT` read 0.
- R4: Pin n's mode code is a 3-bit field at bit n×4 of word 9 for n < 8, and at bit (n−8)×4 of word 10 for n ≥ 8. Bit 3 of each field, and fields of absent pins, read 0.
- R5: Edge modes compare the synchronised level with its value one cycle earlier. Code 0 sets status on a 1→0 change, code 1 on a 0→1 change, and code 4 on either change. The status bit is visible one edge after the change reaches the synchronised level.
- R6: Level modes (code 2 for low, code 3 for high) set status on every cycle in which the synchronised level matches. A clear therefore has no lasting effect while the level persists.
- R7: Status sets only for pins whose enable bit is 1. Codes 5, 6 and 7 never set status.
- R8: Writing word 3 clears the status bits written as 1 and leaves the bits written as 0 unchanged. If a new event arrives in the same cycle, the status bit stays set.
- R9: Writing 1s to word 4 sets those mask bits, and writing 1s to word 5 clears them. Zero bits leave the mask as it is. Word 4 reads the mask state and word 5 reads 0.
- R10: The display (word 2) reads status AND NOT mask, and `irqOut` is the OR of the display bits.
- R11: Writing 1 to bit 0 of word 15 holds every port register at 0 from the next edge onward and ignores register writes. Writing 0 releases the hold, and word 15 reads back the stored bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | PIN_COUNT | Pin levels from the pads, asynchronous |
| pinOut | output | PIN_COUNT | Output latch driven to the pads |
| pinOe | output | PIN_COUNT | Output enable per pin (direction register) |
| irqOut | output | 1 | Combined interrupt, OR of unmasked status |

## Verification
The bench targets the points where a detector or a status register is easily wrong. A level-mode pin must set its status again right after a clear. A clear that coincides with a new event must not drop it. Codes 5–7 must stay silent, and edges on disabled pins must be ignored. A design that confused these would lose interrupts or raise spurious ones. The bench also covers the packing of the mode fields across the two registers, the forcing to 0 of bits above the pin count (12 in the bench), and the soft-reset hold. A design that got these wrong would read back corrupt mode codes, stray direction bits, or registers that survive a soft reset.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word indices within the register window
  localparam logic [3:0] REG_ENABLE  = 4'd0;
  localparam logic [3:0] REG_STATUS  = 4'd1;
  localparam logic [3:0] REG_DISPLAY = 4'd2;
  localparam logic [3:0] REG_CLEAR   = 4'd3;
  localparam logic [3:0] REG_MASKSET = 4'd4;
  localparam logic [3:0] REG_MASKCLR = 4'd5;
  localparam logic [3:0] REG_OUTPUT  = 4'd6;
  localparam logic [3:0] REG_INPUT   = 4'd7;
  localparam logic [3:0] REG_DIR     = 4'd8;
  localparam logic [3:0] REG_MODELO  = 4'd9;
  localparam logic [3:0] REG_MODEHI  = 4'd10;
  localparam logic [3:0] REG_UNUSED  = 4'd11;
  localparam logic [3:0] REG_SRST    = 4'd15;

  // Detector mode codes
  localparam logic [2:0] MODE_FALL = 3'd0;
  localparam logic [2:0] MODE_RISE = 3'd1;
  localparam logic [2:0] MODE_LOW  = 3'd2;
  localparam logic [2:0] MODE_HIGH = 3'd3;
  localparam logic [2:0] MODE_BOTH = 3'd4;

  localparam int MODE_W       = 3;
  localparam int FIELD_W      = 4;
  localparam int PINS_PER_REG = 8;

  typedef struct packed {
    logic       wrEnable;
    logic       wrClear;
    logic       wrMaskSet;
    logic       wrMaskClr;
    logic       wrOutput;
    logic       wrDir;
    logic       wrModeLo;
    logic       wrModeHi;
    logic       holdRst;
    logic [3:0] rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut,
  output logic [WIDTH-1:0] prevOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
      prevOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
      prevOut <= syncOut;
    end
  end

  // Two edges of latency from pin to synchronised level
  assert_two_stage_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN, 2) |-> (syncOut == $past(asyncIn, 2)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              curLvl,
  input  logic              prevLvl,
  output logic              hit
);
  always_comb begin
    unique case (mode)
      MODE_FALL: hit = prevLvl & ~curLvl;
      MODE_RISE: hit = curLvl & ~prevLvl;
      MODE_LOW:  hit = ~curLvl;
      MODE_HIGH: hit = curLvl;
      MODE_BOTH: hit = curLvl ^ prevLvl;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output ctrlStrobes_t      st
);
  localparam int WORD_LSB = 2;
  localparam int WORD_W   = 4;
  localparam int HIGH_LSB = WORD_LSB + WORD_W;

  logic [WORD_W-1:0] word;
  logic              inWindow;
  logic              wrHit;
  logic              srstQ;

  assign word     = busAddr[WORD_LSB +: WORD_W];
  assign inWindow = (busAddr[ADDR_W-1:HIGH_LSB] == '0);
  assign wrHit    = busWrEn & inWindow;

  wire unusedCtrl = ^{busAddr[WORD_LSB-1:0], busWrData[31:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          srstQ <= 1'b0;
    else if (wrHit && word == REG_SRST) srstQ <= busWrData[0];
  end

  always_comb begin
    st           = '0;
    st.wrEnable  = wrHit && word == REG_ENABLE;
    st.wrClear   = wrHit && word == REG_CLEAR;
    st.wrMaskSet = wrHit && word == REG_MASKSET;
    st.wrMaskClr = wrHit && word == REG_MASKCLR;
    st.wrOutput  = wrHit && word == REG_OUTPUT;
    st.wrDir     = wrHit && word == REG_DIR;
    st.wrModeLo  = wrHit && word == REG_MODELO;
    st.wrModeHi  = wrHit && word == REG_MODEHI;
    st.holdRst   = srstQ;
    st.rdSel     = inWindow ? word : REG_UNUSED;
  end

  assert_srst_capture_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && inWindow && word == REG_SRST) |=> (st.holdRst == $past(busWrData[0])));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         st,
  input  logic [31:0]          wrData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [31:0]          rdData,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  localparam int LOW_PINS = (PIN_COUNT < PINS_PER_REG) ? PIN_COUNT : PINS_PER_REG;

  logic [PIN_COUNT-1:0] enableQ, statusQ, maskQ, outQ, dirQ;
  logic [PIN_COUNT-1:0][MODE_W-1:0] modeQ;
  logic [PIN_COUNT-1:0] syncLvl, prevLvl, evtVec;
  logic [PIN_COUNT-1:0] wrBits, clrBits, mSetBits, mClrBits, displayVec;
  logic [31:0] modeLoRd, modeHiRd;

  wire unusedWr = ^wrData;

  assign wrBits   = wrData[PIN_COUNT-1:0];
  assign clrBits  = st.wrClear   ? wrBits : '0;
  assign mSetBits = st.wrMaskSet ? wrBits : '0;
  assign mClrBits = st.wrMaskClr ? wrBits : '0;

  gpio_irq_sync #(.WIDTH(PIN_COUNT)) syncInst (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncLvl),
    .prevOut (prevLvl)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    gpio_irq_detect detInst (
      .mode    (modeQ[p]),
      .curLvl  (syncLvl[p]),
      .prevLvl (prevLvl[p]),
      .hit     (evtVec[p])
    );

    if (p < PINS_PER_REG) begin : g_lo
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           modeQ[p] <= MODE_FALL;
        else if (st.holdRst) modeQ[p] <= MODE_FALL;
        else if (st.wrModeLo) modeQ[p] <= wrData[p*FIELD_W +: MODE_W];
      end
    end else begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           modeQ[p] <= MODE_FALL;
        else if (st.holdRst) modeQ[p] <= MODE_FALL;
        else if (st.wrModeHi) modeQ[p] <= wrData[(p-PINS_PER_REG)*FIELD_W +: MODE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      maskQ   <= '0;
      outQ    <= '0;
      dirQ    <= '0;
    end else if (st.holdRst) begin
      enableQ <= '0;
      statusQ <= '0;
      maskQ   <= '0;
      outQ    <= '0;
      dirQ    <= '0;
    end else begin
      if (st.wrEnable) enableQ <= wrBits;
      if (st.wrOutput) outQ    <= wrBits;
      if (st.wrDir)    dirQ    <= wrBits;
      maskQ   <= (maskQ & ~mClrBits) | mSetBits;
      statusQ <= (statusQ & ~clrBits) | (evtVec & enableQ);
    end
  end

  assign displayVec = statusQ & ~maskQ;
  assign irqOut     = |displayVec;
  assign pinOut     = outQ;
  assign pinOe      = dirQ;

  function automatic logic [31:0] zext(input logic [PIN_COUNT-1:0] v);
    logic [31:0] r;
    r = '0;
    r[PIN_COUNT-1:0] = v;
    return r;
  endfunction

  always_comb begin
    modeLoRd = '0;
    modeHiRd = '0;
    for (int i = 0; i < LOW_PINS; i++) modeLoRd[i*FIELD_W +: MODE_W] = modeQ[i];
    for (int i = PINS_PER_REG; i < PIN_COUNT; i++)
      modeHiRd[(i-PINS_PER_REG)*FIELD_W +: MODE_W] = modeQ[i];
  end

  always_comb begin
    case (st.rdSel)
      REG_ENABLE:  rdData = zext(enableQ);
      REG_STATUS:  rdData = zext(statusQ);
      REG_DISPLAY: rdData = zext(displayVec);
      REG_MASKSET: rdData = zext(maskQ);
      REG_OUTPUT:  rdData = zext(outQ);
      REG_INPUT:   rdData = zext(syncLvl);
      REG_DIR:     rdData = zext(dirQ);
      REG_MODELO:  rdData = modeLoRd;
      REG_MODEHI:  rdData = modeHiRd;
      REG_SRST:    rdData = {31'd0, st.holdRst};
      default:     rdData = '0;
    endcase
  end

  // Status never rises on a pin that was disabled in the cycle before
  assert_no_unenabled_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ) & ~$past(enableQ)) == '0));

  // Every enabled event is captured on the next edge, clear or not (R5, R6)
  assert_event_captured_R6: assert property (@(posedge clk) disable iff (!rstN)
    !st.holdRst |=> ((~statusQ & $past(evtVec & enableQ)) == '0));

  // Cleared bits without a coinciding event read 0 afterwards
  assert_clear_effect_R8: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrClear && !st.holdRst) |=>
      ((statusQ & $past(wrData[PIN_COUNT-1:0] & ~(evtVec & enableQ))) == '0));

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrMaskSet && !st.holdRst) |=>
      ((maskQ & $past(wrData[PIN_COUNT-1:0])) == $past(wrData[PIN_COUNT-1:0])));

  assert_hold_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    st.holdRst |=> (statusQ == '0 && enableQ == '0 && maskQ == '0 && dirQ == '0 && outQ == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  ctrlStrobes_t st;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .st        (st)
  );

  gpio_irq_datapath #(.PIN_COUNT(PIN_COUNT)) dpInst (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .wrData (busWrData),
    .pinIn  (pinIn),
    .rdData (busRdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqOut (irqOut)
  );

  // Interrupt output reflects unmasked status only (R10)
  assert_irq_quiet_when_masked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrMaskSet && !st.holdRst && busWrData[PIN_COUNT-1:0] == '1) |=> !irqOut);

endmodule

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  localparam int P  = 12;
  localparam int AW = 8;

  localparam logic [AW-1:0] A_EN = 8'd0,  A_ST = 8'd4,  A_DISP = 8'd8,  A_CLR = 8'd12;
  localparam logic [AW-1:0] A_MSET = 8'd16, A_MCLR = 8'd20, A_OUT = 8'd24, A_IN = 8'd28;
  localparam logic [AW-1:0] A_DIR = 8'd32, A_M0 = 8'd36, A_M1 = 8'd40, A_SRST = 8'd60;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [P-1:0]  pinIn = '0;
  logic [P-1:0]  pinOut, pinOe;
  logic          irqOut;

  always #4 clk = ~clk;

  gpio_irq_port #(.PIN_COUNT(P), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // Reference model state
  logic [P-1:0] mEn = '0, mSt = '0, mMask = '0, mOut = '0, mDir = '0;
  logic [P-1:0] mS1 = '0, mS2 = '0, mPrev = '0;
  logic [2:0]   mMode [P];
  logic         mSrst = 1'b0;

  int    nChk = 0;
  int    nBad = 0;
  bit    finished = 1'b0;
  string curTag = "";

  function automatic string tagFor(input int w);
    case (w)
      0: return "R7";  1: return "R5";  2: return "R10"; 4, 5: return "R9";
      6, 8: return "R2"; 7: return "R3"; 9, 10: return "R4"; 15: return "R11";
      3: return "R8";
      default: return "R1";
    endcase
  endfunction

  function automatic logic [31:0] ext(input logic [P-1:0] v);
    logic [31:0] r;
    r = '0;
    r[P-1:0] = v;
    return r;
  endfunction

  function automatic logic [31:0] expRead(input logic [AW-1:0] a);
    logic [31:0] r;
    r = '0;
    if (a[AW-1:6] != '0) return r;
    case (int'(a[5:2]))
      0: r = ext(mEn);
      1: r = ext(mSt);
      2: r = ext(mSt & ~mMask);
      4: r = ext(mMask);
      6: r = ext(mOut);
      7: r = ext(mS2);
      8: r = ext(mDir);
      9:  for (int i = 0; i < 8 && i < P; i++) r[i*4 +: 3] = mMode[i];
      10: for (int i = 8; i < P; i++) r[(i-8)*4 +: 3] = mMode[i];
      15: r = {31'd0, mSrst};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic evtFor(input logic [2:0] m, input logic c, input logic p);
    case (m)
      3'd0: return p & ~c;
      3'd1: return c & ~p;
      3'd2: return ~c;
      3'd3: return c;
      3'd4: return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelEdge(input logic wr, input logic [AW-1:0] a,
                           input logic [31:0] d, input logic [P-1:0] pins);
    logic [P-1:0] evt;
    logic hit;
    int w;
    hit = wr && (a[AW-1:6] == '0);
    w = int'(a[5:2]);
    for (int i = 0; i < P; i++) evt[i] = evtFor(mMode[i], mS2[i], mPrev[i]);
    if (mSrst) begin
      mEn = '0; mSt = '0; mMask = '0; mOut = '0; mDir = '0;
      for (int i = 0; i < P; i++) mMode[i] = 3'd0;
    end else begin
      mSt = (mSt & ~((hit && w == 3) ? d[P-1:0] : '0)) | (evt & mEn);
      if (hit && w == 0) mEn = d[P-1:0];
      if (hit && w == 4) mMask = mMask | d[P-1:0];
      if (hit && w == 5) mMask = mMask & ~d[P-1:0];
      if (hit && w == 6) mOut = d[P-1:0];
      if (hit && w == 8) mDir = d[P-1:0];
      if (hit && w == 9)  for (int i = 0; i < 8 && i < P; i++) mMode[i] = d[i*4 +: 3];
      if (hit && w == 10) for (int i = 8; i < P; i++) mMode[i] = d[(i-8)*4 +: 3];
    end
    if (hit && w == 15) mSrst = d[0];
    mPrev = mS2;
    mS2   = mS1;
    mS1   = pins;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h (addr %h, t=%0t)", tag, act, exp, busAddr, $time);
    end
  endtask

  task automatic step(input logic wr, input logic [AW-1:0] a,
                      input logic [31:0] d, input logic [P-1:0] pins);
    string t;
    @(negedge clk);
    busWrEn = wr; busAddr = a; busWrData = d; pinIn = pins;
    #1;
    t = (curTag != "") ? curTag : tagFor(int'(a[5:2]));
    chk(t, busRdData, expRead(a));
    chk((curTag != "") ? curTag : "R2", ext(pinOe), ext(mDir));
    chk((curTag != "") ? curTag : "R2", ext(pinOut), ext(mOut));
    chk((curTag != "") ? curTag : "R10", {31'd0, irqOut}, {31'd0, |(mSt & ~mMask)});
    @(posedge clk);
    #1;
    modelEdge(wr, a, d, pins);
  endtask

  task automatic wrReg(input logic [AW-1:0] a, input logic [31:0] d, input logic [P-1:0] pins);
    step(1'b1, a, d, pins);
  endtask

  task automatic rdReg(input logic [AW-1:0] a, input logic [P-1:0] pins);
    step(1'b0, a, 32'd0, pins);
  endtask

  initial begin
    for (int i = 0; i < P; i++) mMode[i] = 3'd0;
  end

  initial begin
    int seedDummy;
    logic [AW-1:0] ra;
    logic [P-1:0] rp;
    seedDummy = $urandom(32'h5EED_0A17);
    rp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state on every word
    curTag = "R1";
    for (int w = 0; w < 16; w++) rdReg(AW'(w * 4), '0);

    // R2: direction/output and forced-zero upper bits
    curTag = "R2";
    wrReg(A_DIR, 32'hFFFF_FFFF, '0);
    wrReg(A_OUT, 32'hFFFF_FFFF, '0);
    rdReg(A_DIR, '0);
    rdReg(A_OUT, '0);
    wrReg(A_DIR, 32'h0000_0A5A, '0);
    wrReg(A_OUT, 32'h0000_0C3C, '0);
    rdReg(A_DIR, '0);

    // R4: mode field packing
    curTag = "R4";
    wrReg(A_M0, 32'hFFFF_FFFF, '0);
    wrReg(A_M1, 32'hFFFF_FFFF, '0);
    rdReg(A_M0, '0);
    rdReg(A_M1, '0);
    wrReg(A_M0, 32'h4321_0432, '0);
    wrReg(A_M1, 32'h0000_1234, '0);
    rdReg(A_M0, '0);
    rdReg(A_M1, '0);

    // R3: synchronised input readback
    curTag = "R3";
    rdReg(A_IN, 12'hA5C);
    rdReg(A_IN, 12'hA5C);
    rdReg(A_IN, 12'h3F0);
    rdReg(A_IN, 12'h3F0);
    rdReg(A_IN, 12'h3F0);

    // R7: disabled pins and codes 5..7 do not latch
    curTag = "R7";
    wrReg(A_M0, 32'h3333_3333, 12'h000);
    wrReg(A_M1, 32'h0000_3333, 12'hFFF);
    for (int k = 0; k < 4; k++) rdReg(A_ST, 12'hFFF);
    wrReg(A_M0, 32'h5676_7565, 12'h000);
    wrReg(A_M1, 32'h0000_7656, 12'hFFF);
    wrReg(A_EN, 32'hFFFF_FFFF, 12'h000);
    for (int k = 0; k < 6; k++) rdReg(A_ST, (k % 2) ? 12'hFFF : 12'h000);

    // R5: rising, then both edges
    curTag = "R5";
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h000);
    wrReg(A_M0, 32'h1111_1111, 12'h000);
    wrReg(A_M1, 32'h0000_1111, 12'h000);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h000);
    for (int k = 0; k < 5; k++) rdReg(A_ST, 12'h0F3);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h000);
    for (int k = 0; k < 5; k++) rdReg(A_ST, 12'h000);
    wrReg(A_M0, 32'h4444_4444, 12'h000);
    wrReg(A_M1, 32'h0000_4444, 12'h000);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h800);
    for (int k = 0; k < 5; k++) rdReg(A_ST, 12'h801);
    wrReg(A_M0, 32'h0000_0000, 12'h801);
    wrReg(A_M1, 32'h0000_0000, 12'h801);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h801);
    for (int k = 0; k < 5; k++) rdReg(A_ST, 12'h000);

    // R6: high level re-asserts after clear
    curTag = "R6";
    wrReg(A_M0, 32'h3333_3333, 12'hFFF);
    wrReg(A_M1, 32'h0000_3333, 12'hFFF);
    for (int k = 0; k < 3; k++) rdReg(A_ST, 12'hFFF);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'hFFF);
    rdReg(A_ST, 12'hFFF);
    wrReg(A_M0, 32'h2222_2222, 12'h000);
    wrReg(A_M1, 32'h0000_2222, 12'h000);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'h000);
    for (int k = 0; k < 3; k++) rdReg(A_ST, 12'h000);

    // R8: zero bits have no effect, partial clear
    curTag = "R8";
    wrReg(A_M0, 32'h0000_0000, 12'hFFF);
    wrReg(A_M1, 32'h0000_0000, 12'hFFF);
    wrReg(A_CLR, 32'hFFFF_FFFF, 12'hFFF);
    for (int k = 0; k < 4; k++) rdReg(A_ST, 12'h000);
    wrReg(A_CLR, 32'h0000_0000, 12'h000);
    rdReg(A_ST, 12'h000);
    wrReg(A_CLR, 32'h0000_0F0F, 12'h000);
    rdReg(A_ST, 12'h000);

    // R9/R10: mask set/clear and display
    curTag = "R9";
    wrReg(A_MSET, 32'h0000_00F0, 12'h000);
    wrReg(A_MSET, 32'h0000_0800, 12'h000);
    rdReg(A_MSET, 12'h000);
    wrReg(A_MCLR, 32'h0000_0030, 12'h000);
    rdReg(A_MCLR, 12'h000);
    rdReg(A_MSET, 12'h000);
    curTag = "R10";
    rdReg(A_DISP, 12'h000);
    wrReg(A_MSET, 32'hFFFF_FFFF, 12'h000);
    rdReg(A_DISP, 12'h000);
    wrReg(A_MCLR, 32'h0000_0400, 12'h000);
    rdReg(A_DISP, 12'h000);

    // R11: soft reset hold and release
    curTag = "R11";
    wrReg(A_DIR, 32'h0000_0FFF, 12'h000);
    wrReg(A_SRST, 32'h0000_0001, 12'h000);
    rdReg(A_SRST, 12'h000);
    wrReg(A_EN, 32'h0000_0FFF, 12'h000);
    rdReg(A_EN, 12'h000);
    rdReg(A_ST, 12'h000);
    rdReg(A_M0, 12'h000);
    wrReg(A_SRST, 32'h0000_0000, 12'h000);
    wrReg(A_EN, 32'h0000_0123, 12'h000);
    rdReg(A_EN, 12'h000);
    rdReg(A_SRST, 12'h000);

    // Random phase, checked against the model
    curTag = "";
    for (int n = 0; n < 3000; n++) begin
      ra = AW'(($urandom % 16) * 4);
      if (($urandom % 16) == 0) ra[7] = 1'b1;
      if (ra == A_SRST && ($urandom % 4) != 0) ra = A_CLR;
      if (($urandom % 4) == 0) rp = P'($urandom);
      step(($urandom % 3) == 0, ra, $urandom, rp);
    end
    if (mSrst) wrReg(A_SRST, 32'd0, rp);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

endmodule